// File: doc/BRIEF.md
# Multi-Rate UART Baud Enable Generator

This block turns a 50 MHz system clock into a strobe that is one clock wide and recurs at sixteen times a chosen serial bit rate. UART transmit and receive logic use the strobe as their oversampling clock enable. A 2-bit select, normally wired to slide switches, picks one of four standard rates: 19200, 38400, 57600 or 115200 baud. The block also returns the select it is using, so that two LEDs can show the choice.

The division runs in two stages. The four rates are whole multiples of the slowest one, so a per-rate divisor table is not needed. The first stage is a free-running modulo-27 prescaler. It emits one tick per 27 clocks, which is the 16x rate for 115200 baud; this is about 541 Hz fast, under 0.5 %, and is accepted. The second stage counts those ticks and passes every 1st, 2nd, 3rd or 6th of them, depending on the select. At the fastest setting the tick passes straight through.

When the select changes, the tick counter is cleared. The first strobe at the new rate therefore never arrives sooner than one full period of the new rate after the last strobe.

Top module: `baud_enable_gen`

## Requirements
- R1: While `rst` is high, `baud16_en` is 0 and `rate_led` takes the value of `rate_sel` at each clock.
- R2: With `rate_sel` = 2'b11 held through reset, the first strobe appears on the 27th rising edge after reset is released. Later strobes are exactly 27 clocks apart.
- R3: `rate_led` equals the value `rate_sel` had one clock earlier.
- R4: With the select held steady, strobes are 162 clocks apart for 2'b00, 81 clocks apart for 2'b01 and 54 clocks apart for 2'b10.
- R5: Every strobe on `baud16_en` is high for exactly one clock, at every setting.
- R6: After any change of `rate_sel`, the tick counter restarts from zero. The interval from the last strobe before the change to the first strobe after it is at least the period of the new setting.
- R7: At setting 2'b11 every prescaler tick becomes a strobe, with no second-stage division.
- R8: With `rate_sel` = 2'b00 held through reset, the first strobe appears on the 162nd rising edge after reset is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 50 MHz system clock |
| rst | input | 1 | Synchronous reset, active high |
| rate_sel | input | 2 | Rate choice: 00 = 19200, 01 = 38400, 10 = 57600, 11 = 115200 baud |
| baud16_en | output | 1 | Strobe one clock wide at 16x the selected baud rate |
| rate_led | output | 2 | Registered copy of the select in use |

## Verification
The hardest case to reach from the ports is a select change that lands partway through a long period, just before a prescaler tick. In that position a counter that was not cleared would emit a shortened interval. The stimulus changes the select at different phases: right after a strobe, and many clocks after one. It also moves in both directions, from slow rates to fast and from fast to slow. For each change, the bench measures the gap from the last old strobe to the first new one and then the steady interval after it.

// File: rtl/baudgen_pkg.sv
package baudgen_pkg;

    typedef enum logic [1:0] {
        RATE_19K2  = 2'b00,
        RATE_38K4  = 2'b01,
        RATE_57K6  = 2'b10,
        RATE_115K2 = 2'b11
    } rate_e;

    localparam int unsigned MAX_RATIO = 6;
    localparam int unsigned SUB_W     = $clog2(MAX_RATIO);

    function automatic logic [SUB_W-1:0] ratio_of(input rate_e r);
        case (r)
            RATE_19K2:  ratio_of = SUB_W'(6);
            RATE_38K4:  ratio_of = SUB_W'(3);
            RATE_57K6:  ratio_of = SUB_W'(2);
            default:    ratio_of = SUB_W'(1);
        endcase
    endfunction

endpackage

// File: rtl/baud_prescaler.sv
module baud_prescaler #(
    parameter int unsigned PRESCALE = 27
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int unsigned CNT_W = $clog2(PRESCALE);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PRESCALE - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (cnt_q == LAST)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    assign tick = (cnt_q == LAST);

    AST_PRESCALE_WRAP: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == LAST) |=> (cnt_q == '0)); // R2
    AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick); // R5

endmodule

// File: rtl/baud_subdivider.sv
module baud_subdivider
    import baudgen_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             restart,
    input  logic [SUB_W-1:0] ratio,
    output logic             strobe
);
    logic [SUB_W-1:0] sub_q;
    logic             last;
    logic             bypass;

    assign bypass = (ratio == SUB_W'(1));
    assign last   = (sub_q == ratio - 1'b1);

    always_ff @(posedge clk) begin
        if (rst || restart)
            sub_q <= '0;
        else if (tick)
            sub_q <= last ? '0 : sub_q + 1'b1;
    end

    assign strobe = tick && !restart && (bypass || last);

    AST_SUB_CLEAR: assert property (@(posedge clk) disable iff (rst)
        restart |=> (sub_q == '0)); // R6
    AST_SUB_BOUND: assert property (@(posedge clk) disable iff (rst)
        !restart |-> (sub_q < ratio)); // R4
    AST_BYPASS_PASS: assert property (@(posedge clk) disable iff (rst)
        (bypass && tick && !restart) |-> strobe); // R7

endmodule

// File: rtl/baud_enable_gen.sv
module baud_enable_gen
    import baudgen_pkg::*;
#(
    parameter int unsigned PRESCALE = 27
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] rate_sel,
    output logic       baud16_en,
    output logic [1:0] rate_led
);
    localparam int unsigned MAX_GAP = PRESCALE * MAX_RATIO;
    localparam int unsigned GAP_W   = $clog2(MAX_GAP + 2);

    rate_e            sel_q;
    logic             sel_change;
    logic             fast_tick;
    logic             strobe;
    logic             en_q;
    logic [SUB_W-1:0] ratio;

    always_ff @(posedge clk) begin
        sel_q <= rate_e'(rate_sel);
    end

    assign sel_change = !rst && (rate_e'(rate_sel) != sel_q);
    assign ratio      = ratio_of(sel_q);

    baud_prescaler #(.PRESCALE(PRESCALE)) u_prescaler (
        .clk  (clk),
        .rst  (rst),
        .tick (fast_tick)
    );

    baud_subdivider u_subdivider (
        .clk     (clk),
        .rst     (rst),
        .tick    (fast_tick),
        .restart (sel_change),
        .ratio   (ratio),
        .strobe  (strobe)
    );

    always_ff @(posedge clk) begin
        if (rst)
            en_q <= 1'b0;
        else
            en_q <= strobe;
    end

    assign baud16_en = en_q;
    assign rate_led  = sel_q;

    // gap monitor for the minimum-interval property
    logic [GAP_W-1:0] gap_q;
    logic             seen_q;
    logic [SUB_W-1:0] pulse_ratio_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap_q         <= '0;
            seen_q        <= 1'b0;
            pulse_ratio_q <= SUB_W'(1);
        end else begin
            if (en_q) begin
                gap_q  <= GAP_W'(1);
                seen_q <= 1'b1;
            end else if (gap_q != GAP_W'(MAX_GAP + 1)) begin
                gap_q <= gap_q + 1'b1;
            end
            if (strobe)
                pulse_ratio_q <= ratio;
        end
    end

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        baud16_en |=> !baud16_en); // R5
    AST_LED_MIRROR: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (rate_led == $past(rate_sel))); // R3
    AST_MIN_GAP: assert property (@(posedge clk) disable iff (rst)
        (en_q && seen_q) |-> (int'(gap_q) >= int'(PRESCALE) * int'(pulse_ratio_q))); // R6

endmodule

// File: tb/baud_enable_gen_bench.sv
module baud_enable_gen_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] rate_sel = 2'b11;
    logic       baud16_en;
    logic [1:0] rate_led;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    baud_enable_gen u_baud_enable_gen (
        .clk       (clk),
        .rst       (rst),
        .rate_sel  (rate_sel),
        .baud16_en (baud16_en),
        .rate_led  (rate_led)
    );

    typedef struct packed {
        logic [1:0] sel;
        int         period;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{2'b11, 27}, '{2'b00, 162}, '{2'b10, 54}, '{2'b01, 81},
        '{2'b11, 27}, '{2'b10, 54},  '{2'b00, 162}, '{2'b01, 81}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_pulse(output int at);
        int n = 0;
        at = -1;
        while (n < 400) begin
            @(negedge clk);
            if (baud16_en) begin
                at = cyc;
                return;
            end
            n++;
        end
    endtask

    task automatic do_reset(input logic [1:0] s, output int base);
        @(negedge clk);
        rst = 1'b1;
        rate_sel = s;
        repeat (3) @(negedge clk);
        check(baud16_en == 1'b0, "R1 en in reset", int'(baud16_en), 0);
        check(rate_led == s, "R1 led in reset", int'(rate_led), int'(s));
        rst = 1'b0;
        base = cyc;
    endtask

    initial begin
        int base, t0, t1, t2, last;
        // R2: first strobe after reset at 115200
        do_reset(2'b11, base);
        wait_pulse(t0);
        check(t0 - base == 27, "R2 first pulse", t0 - base, 27);
        @(negedge clk);
        check(baud16_en == 1'b0, "R5 width", int'(baud16_en), 0);
        wait_pulse(t1);
        check(t1 - t0 == 27, "R2 steady period", t1 - t0, 27);

        // R8: first strobe after reset at 19200
        do_reset(2'b00, base);
        wait_pulse(t0);
        check(t0 - base == 162, "R8 first pulse", t0 - base, 162);
        last = t0;

        // table walk: change at varying phases
        for (int i = 0; i < NV; i++) begin
            repeat ((i * 7) % 20) @(negedge clk);
            rate_sel = VECS[i].sel;
            @(negedge clk);
            check(rate_led == VECS[i].sel, "R3 led mirror", int'(rate_led), int'(VECS[i].sel));
            if (baud16_en) last = cyc;
            wait_pulse(t1);
            check(t1 - last >= VECS[i].period, "R6 no short gap", t1 - last, VECS[i].period);
            @(negedge clk);
            check(baud16_en == 1'b0, "R5 width", int'(baud16_en), 0);
            wait_pulse(t2);
            check(t2 - t1 == VECS[i].period,
                  (VECS[i].sel == 2'b11) ? "R7 bypass period" : "R4 divided period",
                  t2 - t1, VECS[i].period);
            last = t2;
        end

        // R6: change just before a tick, slow to fast
        rate_sel = 2'b00;
        wait_pulse(t0);
        wait_pulse(t0);
        repeat (150) @(negedge clk);
        rate_sel = 2'b10;
        wait_pulse(t1);
        check(t1 - t0 >= 54, "R6 late change", t1 - t0, 54);
        wait_pulse(t2);
        check(t2 - t1 == 54, "R4 after late change", t2 - t1, 54);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule